// File: doc/BRIEF.md
# Host Port Control Register and Request Arbiter

This block is the core-side control register of a parallel host port, together with the logic that ranks core interrupt sources and drives request pins toward an external host. The core writes one 8-bit control byte over a simple write strobe. Two general-purpose flags in that byte are mirrored into a host-readable status field. A three-bit mode field selects plain request signalling or external DMA handshaking. The block does not contain the data FIFOs, host bus timing, the external DMA controller or vector generation.

The host owns a 4-bit host control register with request enables and two dual-purpose bits. Without DMA, those two bits select split request pins and gate the vectored interrupt acknowledge. With DMA, the same two bits instead choose the DMA transfer direction. Core interrupts use a fixed priority and are reported as one 2-bit source index with a valid bit. This output is recomputed every cycle from the current inputs.

Top module: `hostport_ctrl`

## Requirements
- R1: After reset, the core control byte, the host control register, the status flags and the unsupported-mode flag are all zero.
- R2: A core write (`core_wr`=1) loads `core_wdata` into the control byte at the next rising edge, and `core_ctl` reads it back. Without a write, the byte holds its value. Bit 0 is the receive interrupt enable, bit 1 the transmit interrupt enable, bit 2 the command interrupt enable, bits 4:3 the flags, and bits 7:5 the mode.
- R3: The host-readable `host_flags[1:0]` equal control bits 4:3, bit 0 from bit 3. They change at the same edge that loads the control byte, and each flag can be set or cleared on its own.
- R4: Among the enabled pending sources, command wins and is reported as code 2. Transmit-empty is next as code 1, and receive-full is lowest as code 0.
- R5: `irq_valid` is 1 exactly when at least one source is both pending and enabled in the same cycle. When it is 0, `irq_src` is 0.
- R6: In non-DMA mode with split off (host bit 2 = 0), `hreq` = (host bit 0 AND `hrx_full`) OR (host bit 1 AND `htx_empty`). In this case `hrreq` and `htreq` are 0.
- R7: In non-DMA mode with split on (host bit 2 = 1), `hrreq` = host bit 0 AND `hrx_full`, `htreq` = host bit 1 AND `htx_empty`, and `hreq` is 0.
- R8: In non-DMA mode, `vec_ack` = `hack` AND host bit 3, and `dma_ack` is 0.
- R9: Mode 100 enables DMA, and host bits {3,2} become a transfer select. With 01, `hreq` follows `hrx_full`; with 10, it follows `htx_empty`; with 00 or 11, it is 0. In this mode the host enable bits 0 and 1 are ignored, and `hrreq`, `htreq` and `vec_ack` are 0.
- R10: In DMA mode, `dma_ack` = `hack` when the select is 01 or 10, and 0 otherwise.
- R11: Mode values other than 000 and 100 behave as non-DMA. Writing such a value sets `mode_err`, which then stays set until reset.
- R12: A host write (`host_wr`=1) loads `host_wdata` into the host control register at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_wr | input | 1 | Core control byte write strobe |
| core_wdata | input | 8 | Core control byte write data |
| core_ctl | output | 8 | Core control byte readback |
| host_wr | input | 1 | Host control register write strobe |
| host_wdata | input | 4 | Host control register write data |
| host_flags | output | 2 | Flags mirrored into host status |
| mode_err | output | 1 | Sticky unsupported-mode flag |
| cmd_pend | input | 1 | Host command pending |
| txd_empty | input | 1 | Core transmit data empty |
| rxd_full | input | 1 | Core receive data full |
| irq_valid | output | 1 | Core interrupt request present |
| irq_src | output | 2 | Winning source (2 cmd, 1 tx, 0 rx) |
| hrx_full | input | 1 | Host-side receive data available |
| htx_empty | input | 1 | Host-side transmit register empty |
| hack | input | 1 | Host acknowledge input |
| hreq | output | 1 | Combined or DMA host request |
| hrreq | output | 1 | Split receive request |
| htreq | output | 1 | Split transmit request |
| vec_ack | output | 1 | Vectored interrupt acknowledge |
| dma_ack | output | 1 | DMA acknowledge |

## Verification
The arbiter is tested with every combination of the three pending sources and the three enables. This shows whether a disabled but pending source can still win, or whether a lower source can win over a higher one. The request steering is tested under all four host select/split settings in each of the three mode classes: off, DMA, and unsupported values. These cases show whether the dual-purpose host bits are read correctly and whether the enables are ignored under DMA. Writes of the control byte that toggle one flag at a time show whether each mirrored status bit tracks its flag independently. They also show whether it changes on the same edge as the control byte.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int CTL_W   = 8;
  localparam int HOST_W  = 4;
  localparam int NSRC    = 3;
  localparam int SRCW    = $clog2(NSRC);
  localparam int MODE_W  = 3;
  localparam logic [MODE_W-1:0] MODE_OFF = 3'b000;
  localparam logic [MODE_W-1:0] MODE_DMA = 3'b100;

  // index order gives priority: highest index wins
  localparam int SRC_RX  = 0;
  localparam int SRC_TX  = 1;
  localparam int SRC_CMD = 2;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [1:0]        flags;
    logic              cmd_ie;
    logic              tx_ie;
    logic              rx_ie;
  } core_ctl_t;

  typedef struct packed {
    logic aux;    // vec-ack gate, or select bit 1 under DMA
    logic split;  // split pins, or select bit 0 under DMA
    logic tx_en;
    logic rx_en;
  } host_ctl_t;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    return (m == MODE_OFF) || (m == MODE_DMA);
  endfunction

  function automatic logic mode_is_dma(input logic [MODE_W-1:0] m);
    return m == MODE_DMA;
  endfunction

  function automatic logic [SRCW-1:0] top_src(input logic [NSRC-1:0] p);
    logic [SRCW-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (p[i]) r = SRCW'(i);
    return r;
  endfunction
endpackage

// File: rtl/hpc_core_reg.sv
module hpc_core_reg
  import hpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output core_ctl_t        ctl_q,
  output logic             mode_err,
  output logic             dma_on,
  output logic             bad_wr_evt
);
  core_ctl_t wr_val;

  always_comb begin
    wr_val     = core_ctl_t'(wdata);
    bad_wr_evt = wr && !mode_known(wr_val.mode);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      mode_err <= 1'b0;
    end else begin
      if (wr)         ctl_q    <= wr_val;
      if (bad_wr_evt) mode_err <= 1'b1;
    end
  end

  assign dma_on = mode_is_dma(ctl_q.mode);
endmodule

// File: rtl/hpc_flag_mirror.sv
module hpc_flag_mirror
  import hpc_pkg::*;
#(
  parameter int NFLAG = 2,
  parameter int LSB   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [NFLAG-1:0] flags_q
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)  flags_q[g] <= 1'b0;
      else if (wr) flags_q[g] <= wdata[LSB+g];
    end
  end
endmodule

// File: rtl/hpc_host_reg.sv
module hpc_host_reg
  import hpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [HOST_W-1:0] wdata,
  output host_ctl_t         host_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  host_q <= '0;
    else if (wr) host_q <= host_ctl_t'(wdata);
  end
endmodule

// File: rtl/hpc_irq_arb.sv
module hpc_irq_arb
  import hpc_pkg::*;
(
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] pend,
  output logic            valid,
  output logic [SRCW-1:0] src
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign pend[g] = raw[g] & en[g];
  end

  assign valid = |pend;
  assign src   = top_src(pend);
endmodule

// File: rtl/hpc_req_mux.sv
module hpc_req_mux
  import hpc_pkg::*;
(
  input  logic      dma_on,
  input  host_ctl_t host,
  input  logic      hrx_full,
  input  logic      htx_empty,
  input  logic      hack,
  output logic      hreq,
  output logic      hrreq,
  output logic      htreq,
  output logic      vec_ack,
  output logic      dma_ack
);
  logic       rx_want;
  logic       tx_want;
  logic [1:0] dsel;

  assign rx_want = host.rx_en & hrx_full;
  assign tx_want = host.tx_en & htx_empty;
  assign dsel    = {host.aux, host.split};

  always_comb begin
    hreq    = 1'b0;
    hrreq   = 1'b0;
    htreq   = 1'b0;
    vec_ack = 1'b0;
    dma_ack = 1'b0;
    if (dma_on) begin
      case (dsel)
        2'b01: begin hreq = hrx_full;  dma_ack = hack; end
        2'b10: begin hreq = htx_empty; dma_ack = hack; end
        default: ;
      endcase
    end else begin
      if (host.split) begin
        hrreq = rx_want;
        htreq = tx_want;
      end else begin
        hreq = rx_want | tx_want;
      end
      vec_ack = hack & host.aux;
    end
  end
endmodule

// File: rtl/hostport_ctrl.sv
module hostport_ctrl
  import hpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        core_wr,
  input  logic [7:0]  core_wdata,
  output logic [7:0]  core_ctl,
  input  logic        host_wr,
  input  logic [3:0]  host_wdata,
  output logic [1:0]  host_flags,
  output logic        mode_err,
  input  logic        cmd_pend,
  input  logic        txd_empty,
  input  logic        rxd_full,
  output logic        irq_valid,
  output logic [1:0]  irq_src,
  input  logic        hrx_full,
  input  logic        htx_empty,
  input  logic        hack,
  output logic        hreq,
  output logic        hrreq,
  output logic        htreq,
  output logic        vec_ack,
  output logic        dma_ack
);
  core_ctl_t       ctl_q;
  host_ctl_t       host_q;
  logic            dma_on;
  logic            bad_wr_evt;
  logic [NSRC-1:0] src_raw;
  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] src_pend;

  hpc_core_reg u_core (
    .clk(clk), .rst_n(rst_n), .wr(core_wr), .wdata(core_wdata),
    .ctl_q(ctl_q), .mode_err(mode_err), .dma_on(dma_on),
    .bad_wr_evt(bad_wr_evt)
  );

  hpc_flag_mirror #(.NFLAG(2), .LSB(3)) u_mirror (
    .clk(clk), .rst_n(rst_n), .wr(core_wr), .wdata(core_wdata),
    .flags_q(host_flags)
  );

  hpc_host_reg u_host (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wdata(host_wdata),
    .host_q(host_q)
  );

  always_comb begin
    src_raw          = '0;
    src_en           = '0;
    src_raw[SRC_RX]  = rxd_full;
    src_raw[SRC_TX]  = txd_empty;
    src_raw[SRC_CMD] = cmd_pend;
    src_en[SRC_RX]   = ctl_q.rx_ie;
    src_en[SRC_TX]   = ctl_q.tx_ie;
    src_en[SRC_CMD]  = ctl_q.cmd_ie;
  end

  hpc_irq_arb u_arb (
    .raw(src_raw), .en(src_en), .pend(src_pend),
    .valid(irq_valid), .src(irq_src)
  );

  hpc_req_mux u_mux (
    .dma_on(dma_on), .host(host_q), .hrx_full(hrx_full),
    .htx_empty(htx_empty), .hack(hack), .hreq(hreq), .hrreq(hrreq),
    .htreq(htreq), .vec_ack(vec_ack), .dma_ack(dma_ack)
  );

  assign core_ctl = ctl_q;
endmodule

// File: rtl/hpc_ctrl_chk.sv
module hpc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_wr,
  input logic [7:0] core_wdata,
  input logic [7:0] core_ctl,
  input logic [1:0] host_flags,
  input logic       mode_err,
  input logic       bad_wr_evt,
  input logic       dma_on,
  input logic       cmd_pend,
  input logic       txd_empty,
  input logic       irq_valid,
  input logic [1:0] irq_src,
  input logic       hreq,
  input logic       hrreq,
  input logic       htreq,
  input logic       vec_ack,
  input logic       dma_ack
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |=> core_ctl == $past(core_wdata));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !core_wr |=> $stable(core_ctl));
  p_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_flags == core_ctl[4:3]);
  p_cmd_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pend && core_ctl[2]) |-> (irq_valid && irq_src == 2'd2));
  p_tx_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_pend && core_ctl[2]) && txd_empty && core_ctl[1])
      |-> (irq_valid && irq_src == 2'd1));
  p_idle_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_src == 2'd0);
  p_split_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hreq && (hrreq || htreq)));
  p_dma_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_on |-> (!hrreq && !htreq && !vec_ack));
  p_ack_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_ack && dma_ack));
  p_err_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr_evt |=> mode_err);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);
endmodule

bind hostport_ctrl hpc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_wr(core_wr), .core_wdata(core_wdata),
  .core_ctl(core_ctl), .host_flags(host_flags), .mode_err(mode_err),
  .bad_wr_evt(bad_wr_evt), .dma_on(dma_on), .cmd_pend(cmd_pend),
  .txd_empty(txd_empty), .irq_valid(irq_valid), .irq_src(irq_src),
  .hreq(hreq), .hrreq(hrreq), .htreq(htreq), .vec_ack(vec_ack),
  .dma_ack(dma_ack)
);

// File: tb/sim_hostport_ctrl.sv
module sim_hostport_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       core_wr = 1'b0;
  logic [7:0] core_wdata = '0;
  logic       host_wr = 1'b0;
  logic [3:0] host_wdata = '0;
  logic       cmd_pend = 1'b0, txd_empty = 1'b0, rxd_full = 1'b0;
  logic       hrx_full = 1'b0, htx_empty = 1'b0, hack = 1'b0;
  logic [7:0] core_ctl;
  logic [1:0] host_flags, irq_src;
  logic       mode_err, irq_valid, hreq, hrreq, htreq, vec_ack, dma_ack;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_ctl = '0;
  logic [3:0] m_host = '0;
  logic       m_err = 1'b0;

  always #5 clk = ~clk;

  hostport_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .core_wr(core_wr), .core_wdata(core_wdata),
    .core_ctl(core_ctl), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_flags(host_flags), .mode_err(mode_err), .cmd_pend(cmd_pend),
    .txd_empty(txd_empty), .rxd_full(rxd_full), .irq_valid(irq_valid),
    .irq_src(irq_src), .hrx_full(hrx_full), .htx_empty(htx_empty),
    .hack(hack), .hreq(hreq), .hrreq(hrreq), .htreq(htreq),
    .vec_ack(vec_ack), .dma_ack(dma_ack)
  );

  // R12 / R2 / R11: reference register updates
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl <= '0; m_host <= '0; m_err <= 1'b0;
    end else begin
      if (core_wr) begin
        m_ctl <= core_wdata;
        if (core_wdata[7:5] != 3'b000 && core_wdata[7:5] != 3'b100) m_err <= 1'b1;
      end
      if (host_wr) m_host <= host_wdata;
    end
  end

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic       e_v, e_hreq, e_rr, e_tr, e_va, e_da, dma;
    logic [1:0] e_src, sel;
    string      rtag, atag;
    e_v = 1'b1;
    if (cmd_pend && m_ctl[2])       e_src = 2;
    else if (txd_empty && m_ctl[1]) e_src = 1;
    else if (rxd_full && m_ctl[0])  e_src = 0;
    else begin e_src = 0; e_v = 1'b0; end
    dma = (m_ctl[7:5] == 3'b100);
    sel = m_host[3:2];
    e_hreq = 0; e_rr = 0; e_tr = 0; e_va = 0; e_da = 0;
    if (dma) begin
      rtag = "R9"; atag = "R10";
      if (sel == 2'b01) begin e_hreq = hrx_full; e_da = hack; end
      if (sel == 2'b10) begin e_hreq = htx_empty; e_da = hack; end
    end else begin
      atag = "R8";
      rtag = (m_ctl[7:5] != 0) ? "R11" : (m_host[2] ? "R7" : "R6");
      if (m_host[2]) begin
        e_rr = m_host[0] & hrx_full;
        e_tr = m_host[1] & htx_empty;
      end else e_hreq = (m_host[0] & hrx_full) | (m_host[1] & htx_empty);
      e_va = hack & m_host[3];
    end
    cmp("R2 ctl", core_ctl, m_ctl);
    cmp("R3 flags", {6'd0, host_flags}, {6'd0, m_ctl[4:3]});
    cmp("R11 err", {7'd0, mode_err}, {7'd0, m_err});
    cmp("R5 valid", {7'd0, irq_valid}, {7'd0, e_v});
    cmp("R4 src", {6'd0, irq_src}, {6'd0, e_src});
    cmp({rtag, " req"}, {5'd0, hreq, hrreq, htreq}, {5'd0, e_hreq, e_rr, e_tr});
    cmp({atag, " ack"}, {6'd0, vec_ack, dma_ack}, {6'd0, e_va, e_da});
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic set_src(input logic [5:0] v);
    {cmd_pend, txd_empty, rxd_full, hrx_full, htx_empty, hack} = v;
  endtask

  initial begin
    #300000;
    nbad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 ctl", core_ctl, 8'h00);
    cmp("R1 flags", {6'd0, host_flags}, 8'h00);
    cmp("R1 err", {7'd0, mode_err}, 8'h00);
    rst_n = 1'b1;
    step();
    // R3: each flag alone, then together
    core_wr = 1; core_wdata = 8'h08; step();
    core_wdata = 8'h10; step();
    core_wdata = 8'h18; step();
    core_wr = 0; step();
    // R4/R5: all pending/enable combinations
    for (int e = 0; e < 8; e++) begin
      core_wr = 1; core_wdata = {5'd0, e[2:0]}; step(); core_wr = 0;
      for (int p = 0; p < 8; p++) begin
        set_src({p[2:0], 3'b000}); step();
      end
    end
    // R6..R10 under off, DMA and unsupported modes
    for (int m = 0; m < 3; m++) begin
      core_wr = 1; core_wdata = (m == 0) ? 8'h00 : (m == 1) ? 8'h80 : 8'h40;
      step(); core_wr = 0;
      for (int h = 0; h < 16; h++) begin
        host_wr = 1; host_wdata = h[3:0]; step(); host_wr = 0;
        for (int s = 0; s < 8; s++) begin
          set_src({3'b000, s[2:0]}); step();
        end
      end
    end
    // mixed random traffic
    rst_n = 0; step(); rst_n = 1;
    for (int i = 0; i < 3000; i++) begin
      core_wr = ($urandom_range(0, 7) == 0);
      core_wdata = $urandom_range(0, 255);
      if ($urandom_range(0, 3) != 0) core_wdata[7:5] = core_wdata[7] ? 3'b100 : 3'b000;
      host_wr = ($urandom_range(0, 5) == 0);
      host_wdata = $urandom_range(0, 15);
      set_src(6'($urandom_range(0, 63)));
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule